// File: doc/BRIEF.md
# Trace Exception Decision Unit

This block sits beside the instruction sequencer of a processor core. At the end of every instruction it decides whether a trace exception has to be raised, based on the trace-mode field of the status register and on what the instruction did. It takes in the following:

- a strobe that marks the start of an instruction;
- a strobe that marks its retirement, together with flags that say whether the instruction wrote the status register, left the program counter off the next sequential address, or was a coprocessor general instruction;
- a strobe for each transfer-status-and-scan-PC primitive that the coprocessor issues, with the primitive's program-flow-change bit.

The trace-mode field is captured when an instruction starts. That captured value governs the instruction to its end, even if the instruction rewrites the field. In flow-change mode a coprocessor general instruction does not use the sequencer's flow and status flags. It is traced only when the coprocessor itself reported a flow change during that instruction. `trace_pending_o` marks the retire cycle of an instruction that must be traced. `take_trace_o` is the one-cycle request, issued once the instruction has finished, that the exception logic acts on.

Top module: `trace_unit`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first traced retirement, `trace_pending_o` and `take_trace_o` are 0.
- R2: With mode code 2'b10 (trace all) captured at instruction start, every retirement raises `trace_pending_o` during the retire cycle.
- R3: With mode code 2'b01 (flow change) and `cp_gen_i`=0, a retirement with `sr_write_i`=1 raises a trace.
- R4: With mode code 2'b01 and `cp_gen_i`=0, a retirement with `flow_chg_i`=1 raises a trace.
- R5: With mode code 2'b01 and `cp_gen_i`=0, a retirement with `sr_write_i`=0 and `flow_chg_i`=0 raises no trace.
- R6: With mode code 2'b01 and `cp_gen_i`=1, a trace is raised if and only if a primitive strobe with `cp_dr_i`=1 occurred during that instruction. `sr_write_i` and `flow_chg_i` have no effect in this case.
- R7: A primitive strobe with `cp_dr_i`=0 does not mark a flow change.
- R8: A flow change marked by a primitive in one instruction is cleared by the next `insn_start_i` and does not trace the following instruction.
- R9: Mode codes 2'b00 and 2'b11 raise no trace.
- R10: The mode is captured by `insn_start_i`. A change of `trace_mode_i` later in the same instruction does not alter that instruction's decision. When start and retire coincide, the live mode is used.
- R11: `take_trace_o` is high for exactly the one cycle after a retire cycle in which `trace_pending_o` was high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_mode_i | input | 2 | Trace-mode field of the status register |
| insn_start_i | input | 1 | First cycle of an instruction |
| insn_retire_i | input | 1 | Retire cycle of the instruction |
| sr_write_i | input | 1 | Instruction wrote the status register (valid at retire) |
| flow_chg_i | input | 1 | Next PC is not the sequential address (valid at retire) |
| cp_gen_i | input | 1 | Instruction is a coprocessor general instruction (valid at retire) |
| cp_prim_i | input | 1 | Transfer-status-and-scan-PC primitive strobe |
| cp_dr_i | input | 1 | Flow-change bit of that primitive |
| trace_pending_o | output | 1 | Trace decided, asserted in the retire cycle |
| take_trace_o | output | 1 | One-cycle take-trace request after retire |

## Verification
The hardest situations to reach are those where history inside an instruction decides the outcome. One is a coprocessor primitive seen cycles before retirement. Another is a primitive left over from the previous instruction. A third is a trace-mode change made partway through an instruction. Each directed scenario therefore drives start, middle and retire cycles separately. It places the primitive and the mode change in the middle cycle, and it chains two coprocessor instructions so that the stale flow-change mark is exposed.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    TM_OFF  = 2'b00,
    TM_FLOW = 2'b01,
    TM_ALL  = 2'b10,
    TM_RSVD = 2'b11
  } trace_mode_e;
endpackage

// File: rtl/trace_mode_latch.sv
module trace_mode_latch
  import trace_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_q_o,
  output trace_mode_e       mode_eff_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= TM_OFF;
    else if (start_i) mode_q <= mode_i;
  end

  assign mode_q_o   = mode_q;
  // single-cycle instruction uses live field
  assign mode_eff_o = trace_mode_e'(start_i ? mode_i : mode_q);
endmodule

// File: rtl/trace_cp_flow.sv
module trace_cp_flow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic prim_i,
  input  logic dr_i,
  output logic dr_q_o,
  output logic dr_hit_o
);
  logic dr_q;
  logic dr_set;

  assign dr_set = prim_i & dr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dr_q <= 1'b0;
    else if (start_i) dr_q <= dr_set;
    else if (dr_set)  dr_q <= 1'b1;
  end

  assign dr_q_o   = dr_q;
  assign dr_hit_o = (dr_q & ~start_i) | dr_set;
endmodule

// File: rtl/trace_decide.sv
module trace_decide
  import trace_pkg::*;
(
  input  trace_mode_e mode_i,
  input  logic        sr_write_i,
  input  logic        flow_chg_i,
  input  logic        cp_gen_i,
  input  logic        dr_hit_i,
  output logic        hit_o
);
  always_comb begin
    unique case (mode_i)
      TM_ALL:  hit_o = 1'b1;
      TM_FLOW: hit_o = cp_gen_i ? dr_hit_i : (sr_write_i | flow_chg_i);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trace_unit.sv
module trace_unit
  import trace_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] trace_mode_i,
  input  logic       insn_start_i,
  input  logic       insn_retire_i,
  input  logic       sr_write_i,
  input  logic       flow_chg_i,
  input  logic       cp_gen_i,
  input  logic       cp_prim_i,
  input  logic       cp_dr_i,
  output logic       trace_pending_o,
  output logic       take_trace_o
);
  logic [MODE_W-1:0] mode_q;
  trace_mode_e       mode_eff;
  logic              dr_q;
  logic              dr_hit;
  logic              hit;
  logic              take_q;

  trace_mode_latch u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (insn_start_i),
    .mode_i    (trace_mode_i),
    .mode_q_o  (mode_q),
    .mode_eff_o(mode_eff)
  );

  trace_cp_flow u_cp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (insn_start_i),
    .prim_i  (cp_prim_i),
    .dr_i    (cp_dr_i),
    .dr_q_o  (dr_q),
    .dr_hit_o(dr_hit)
  );

  trace_decide u_dec (
    .mode_i    (mode_eff),
    .sr_write_i(sr_write_i),
    .flow_chg_i(flow_chg_i),
    .cp_gen_i  (cp_gen_i),
    .dr_hit_i  (dr_hit),
    .hit_o     (hit)
  );

  assign trace_pending_o = insn_retire_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) take_q <= 1'b0;
    else         take_q <= trace_pending_o;
  end

  assign take_trace_o = take_q;
endmodule

// File: rtl/trace_unit_chk.sv
module trace_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] trace_mode_i,
  input logic       insn_start_i,
  input logic       insn_retire_i,
  input logic       sr_write_i,
  input logic       flow_chg_i,
  input logic       cp_gen_i,
  input logic       cp_prim_i,
  input logic       cp_dr_i,
  input logic       trace_pending_o,
  input logic       take_trace_o,
  input logic [1:0] mode_q,
  input logic       dr_q
);
  // R11
  take_after_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trace_o |-> $past(trace_pending_o));

  // R11
  pend_only_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_retire_i |-> !trace_pending_o);

  // R2
  all_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_retire_i && !insn_start_i && mode_q == 2'b10 |-> trace_pending_o);

  // R9
  off_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_start_i && (trace_mode_i == 2'b00 || trace_mode_i == 2'b11) |-> !trace_pending_o);

  // R3
  sr_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_retire_i && !insn_start_i && mode_q == 2'b01 && !cp_gen_i && sr_write_i
    |-> trace_pending_o);

  // R6
  cp_no_dr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_retire_i && !insn_start_i && mode_q == 2'b01 && cp_gen_i && !dr_q
    && !(cp_prim_i && cp_dr_i) |-> !trace_pending_o);

  // R8
  dr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_start_i && !cp_prim_i |=> !dr_q);
endmodule

bind trace_unit trace_unit_chk u_chk (.*);

// File: tb/sim_trace_unit.sv
module sim_trace_unit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       start = 1'b0, retire = 1'b0, srw = 1'b0, fc = 1'b0, cpg = 1'b0;
  logic       prim = 1'b0, dr = 1'b0;
  logic       pend, take;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .trace_mode_i(mode), .insn_start_i(start),
    .insn_retire_i(retire), .sr_write_i(srw), .flow_chg_i(fc), .cp_gen_i(cpg),
    .cp_prim_i(prim), .cp_dr_i(dr), .trace_pending_o(pend), .take_trace_o(take)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // start cycle, middle cycle (optional primitive, mode change), retire cycle
  task automatic run_insn(input logic [1:0] m0, input logic [1:0] m1,
                          input logic s, input logic f, input logic c,
                          input logic p, input logic d,
                          input logic exp, input string tag);
    @(negedge clk);
    start = 1'b1; mode = m0;
    @(negedge clk);
    start = 1'b0; mode = m1; prim = p; dr = d;
    @(negedge clk);
    prim = 1'b0; dr = 1'b0;
    retire = 1'b1; srw = s; fc = f; cpg = c;
    #1 check(pend, exp, {tag, " pending"});
    @(posedge clk); #1 check(take, exp, {tag, " take"});
    @(negedge clk);
    retire = 1'b0; srw = 1'b0; fc = 1'b0; cpg = 1'b0;
    @(posedge clk); #1 check(take, 1'b0, {tag, " R11 pulse end"});
  endtask

  task automatic t_reset;
    #1 check(pend, 1'b0, "R1 pending in reset");
    check(take, 1'b0, "R1 take in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(take, 1'b0, "R1 take after reset");
  endtask

  task automatic t_all;
    run_insn(2'b10, 2'b10, 0, 0, 0, 0, 0, 1'b1, "R2 plain");
    run_insn(2'b10, 2'b10, 0, 0, 1, 0, 0, 1'b1, "R2 cp");
  endtask

  task automatic t_flow;
    run_insn(2'b01, 2'b01, 1, 0, 0, 0, 0, 1'b1, "R3 sr write");
    run_insn(2'b01, 2'b01, 0, 1, 0, 0, 0, 1'b1, "R4 flow change");
    run_insn(2'b01, 2'b01, 0, 0, 0, 0, 0, 1'b0, "R5 sequential");
  endtask

  task automatic t_cp;
    run_insn(2'b01, 2'b01, 0, 0, 1, 1, 1, 1'b1, "R6 dr seen");
    run_insn(2'b01, 2'b01, 1, 1, 1, 0, 0, 1'b0, "R6 flags ignored");
    run_insn(2'b01, 2'b01, 0, 0, 1, 1, 0, 1'b0, "R7 dr zero");
  endtask

  task automatic t_stale;
    run_insn(2'b01, 2'b01, 0, 0, 1, 1, 1, 1'b1, "R8 first");
    run_insn(2'b01, 2'b01, 0, 0, 1, 0, 0, 1'b0, "R8 stale cleared");
  endtask

  task automatic t_off;
    run_insn(2'b00, 2'b00, 1, 1, 0, 0, 0, 1'b0, "R9 off");
    run_insn(2'b11, 2'b11, 1, 1, 1, 1, 1, 1'b0, "R9 reserved");
  endtask

  task automatic t_sample;
    run_insn(2'b10, 2'b00, 0, 0, 0, 0, 0, 1'b1, "R10 on then off");
    run_insn(2'b00, 2'b10, 1, 1, 0, 0, 0, 1'b0, "R10 off then on");
    // single-cycle instruction takes live mode
    @(negedge clk);
    start = 1'b1; retire = 1'b1; mode = 2'b10;
    #1 check(pend, 1'b1, "R10 same-cycle start");
    @(negedge clk);
    start = 1'b0; retire = 1'b0; mode = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_all();
    t_flow();
    t_cp();
    t_stale();
    t_off();
    t_sample();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule